// File: doc/BRIEF.md
# PS/2 Software-Driven Port Controller

This block lets a microcontroller run a PS/2 port entirely in software. Firmware sets the level of the open-drain clock and data lines through bits in a control register. The block pulls a line low by asserting that line's output-enable and releases it otherwise.

Both pin inputs are synchronized and filtered. Every falling edge of the filtered clock line records an event, so firmware can sample or drive the data line within that clock phase.

A direction bit selects transmit or receive. Dropping the direction bit out of transmit releases the data line and sets a transmit-idle status bit. That status bit records an event of its own. The event bits are masked onto a single interrupt output and are cleared when firmware reads them.

Top module: `ps2_bitbang_port`

## Requirements
- R1: After reset, both output-enables are 0 and the interrupt is 0. The control register reads 4'hC, with bits [3:2] set and bits [1:0] clear. The status register reads 4'h7 when both pins are high.
- R2: The control register is at address 0. Bit 0 is port enable, bit 1 is transmit direction, bit 2 is the clock level and bit 3 is the data level. While bit 0 is 0, the clock output-enable equals the inverse of bit 2. While bit 0 is 0 and bit 1 is 1, the data output-enable equals the inverse of bit 3.
- R3: While the transmit direction bit is 0, the data output-enable is 0 whatever the data level bit holds.
- R4: While the port enable bit is 1, both output-enables are 0.
- R5: While port enable is 0, a falling edge on the clock pin sets bit 0 of the event register at address 2. The bit is set on the sixth rising clock edge after the pin changes, with the default filter length of 3. A rising edge on the pin sets nothing.
- R6: A low pulse on an input pin shorter than the filter length, in clock cycles, is ignored: it records no event and does not change the reported level.
- R7: The status register is at address 1. Bit 0 gives the filtered clock pin level, bit 1 the filtered data pin level and bit 2 the transmit-idle flag.
- R8: Writing 1 to the direction bit clears the transmit-idle flag. A write that changes the direction bit from 1 to 0 sets the flag in the next cycle and sets bit 1 of the event register in the same cycle.
- R9: A read of address 2 returns the event bits and clears them. An event arriving on the clock edge that ends the read stays pending.
- R10: The interrupt output is the OR of the event bits ANDed with the mask register at address 3, which resets to 0. Masking hides the interrupt but does not stop events being recorded.
- R11: While port enable is 1, clock falling edges record no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 4 | Write data |
| bus_rdata | output | 4 | Read data, valid in the strobe cycle |
| ps2_clk_in | input | 1 | Clock pin level |
| ps2_dat_in | input | 1 | Data pin level |
| ps2_clk_oe | output | 1 | Pull clock pin low |
| ps2_dat_oe | output | 1 | Pull data pin low |
| irq | output | 1 | Masked interrupt |

## Verification
The bench times a pin fall so that its event lands on the same edge as an event-register read. A design that cleared unconditionally on read would lose that event and report 0 afterwards.

A two-cycle low glitch is applied to the clock pin. A design with a short or missing filter would record an event from it.

The bench also drops the direction bit while the data level bit is 0. A design that kept the data line driven would show an asserted data output-enable.

The bench pulls the clock pin low while the port is enabled. A design that recorded edges in that mode would set the event bit.

// File: rtl/ps2_bitbang_port.sv
module ps2_bitbang_port #(
  parameter int FILT = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [3:0] bus_wdata,
  output logic [3:0] bus_rdata,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       irq
);
  logic en, tx, lvl_clk, lvl_dat, idle;
  logic [1:0] mask, src, s1, s2, filt;
  logic [FILT-1:0] hist [2];
  logic fall_evt, idle_set, rd_src, wr_ctrl;

  assign wr_ctrl  = bus_wr && bus_addr == 2'd0;
  assign rd_src   = bus_rd && bus_addr == 2'd2;
  assign idle_set = wr_ctrl && tx && !bus_wdata[1];
  assign fall_evt = !en && filt[0] && hist[0] == '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 2'b11;
      s2 <= 2'b11;
      filt <= 2'b11;
      for (int i = 0; i < 2; i++) hist[i] <= '1;
    end else begin
      s1 <= {ps2_dat_in, ps2_clk_in};
      s2 <= s1;
      for (int i = 0; i < 2; i++) begin
        hist[i] <= {hist[i][FILT-2:0], s2[i]};
        if (hist[i] == '0) filt[i] <= 1'b0;
        else if (hist[i] == '1) filt[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0;
      tx <= 1'b0;
      lvl_clk <= 1'b1;
      lvl_dat <= 1'b1;
      idle <= 1'b1;
      mask <= 2'b00;
      src <= 2'b00;
    end else begin
      if (wr_ctrl) begin
        {lvl_dat, lvl_clk, tx, en} <= bus_wdata;
        if (bus_wdata[1]) idle <= 1'b0;
        else if (tx) idle <= 1'b1;
      end
      if (bus_wr && bus_addr == 2'd3) mask <= bus_wdata[1:0];
      src <= (rd_src ? 2'b00 : src) | {idle_set, fall_evt};
    end
  end

  always_comb begin
    case (bus_addr)
      2'd0: bus_rdata = {lvl_dat, lvl_clk, tx, en};
      2'd1: bus_rdata = {1'b0, idle, filt[1], filt[0]};
      2'd2: bus_rdata = {2'b00, src};
      default: bus_rdata = {2'b00, mask};
    endcase
  end

  assign ps2_clk_oe = !en && !lvl_clk;
  assign ps2_dat_oe = !en && tx && !lvl_dat;
  assign irq = |(src & mask);
endmodule

module ps2_bitbang_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       tx,
  input logic       idle,
  input logic       rd_src,
  input logic       fall_evt,
  input logic       idle_set,
  input logic [1:0] src,
  input logic [1:0] mask,
  input logic       ps2_clk_oe,
  input logic       ps2_dat_oe,
  input logic       irq
);
  // R4
  enabled_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !ps2_clk_oe && !ps2_dat_oe);
  // R3
  rx_data_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx |-> !ps2_dat_oe);
  // R8
  idle_rise_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> src[1]);
  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd_src && !fall_evt && !idle_set) |-> src == 2'b00);
  // R10
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 2'b00 |-> !irq);
  // R11
  enabled_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(en) |-> !$rose(src[0]));
endmodule

bind ps2_bitbang_port ps2_bitbang_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx(tx), .idle(idle), .rd_src(rd_src),
  .fall_evt(fall_evt), .idle_set(idle_set), .src(src), .mask(mask),
  .ps2_clk_oe(ps2_clk_oe), .ps2_dat_oe(ps2_dat_oe), .irq(irq)
);

// File: tb/tb_ps2_bitbang_port.sv
module tb_ps2_bitbang_port;
  logic clk = 0, rst_n = 0;
  logic [1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_wdata = 0;
  logic [3:0] bus_rdata;
  logic clk_oe, dat_oe, irq;
  logic dev_clk = 1, dev_dat = 1;
  wire pin_clk = dev_clk & ~clk_oe;
  wire pin_dat = dev_dat & ~dat_oe;
  int checks = 0, fails = 0;
  logic [3:0] v;

  always #2.5 clk = ~clk;

  ps2_bitbang_port dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ps2_clk_in(pin_clk), .ps2_dat_in(pin_dat),
    .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe), .irq(irq)
  );

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [3:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #1 d = bus_rdata;
    @(negedge clk); bus_rd = 0;
  endtask

  task automatic idle_cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    #1;
    chk("R1 clk_oe", {3'b0, clk_oe}, 4'h0);
    chk("R1 dat_oe", {3'b0, dat_oe}, 4'h0);
    chk("R1 irq", {3'b0, irq}, 4'h0);
    rd(2'd0, v); chk("R1 ctrl", v, 4'hC);
    rd(2'd1, v); chk("R1 status", v, 4'h7);
  endtask

  task automatic t_lines;
    wr(2'd0, 4'h2); #1;
    chk("R2 clk_oe driven", {3'b0, clk_oe}, 4'h1);
    chk("R2 dat_oe driven", {3'b0, dat_oe}, 4'h1);
    wr(2'd0, 4'hE); #1;
    chk("R2 both released", {2'b0, clk_oe, dat_oe}, 4'h0);
    wr(2'd0, 4'h2);
    wr(2'd0, 4'h0); #1;
    chk("R3 data released on rx", {3'b0, dat_oe}, 4'h0);
    chk("R3 clk still driven", {3'b0, clk_oe}, 4'h1);
    wr(2'd0, 4'h3); #1;
    chk("R4 enabled releases", {2'b0, clk_oe, dat_oe}, 4'h0);
    wr(2'd0, 4'hC); idle_cycles(10);
    rd(2'd2, v);
  endtask

  task automatic t_edge;
    wr(2'd3, 4'h1);
    rd(2'd2, v); chk("R9 cleared before", v, 4'h0);
    @(negedge clk); dev_clk = 0;
    idle_cycles(4); #1;
    chk("R5 not before six edges", {3'b0, irq}, 4'h0);
    idle_cycles(2); #1;
    chk("R5 R10 irq on fall", {3'b0, irq}, 4'h1);
    rd(2'd1, v); chk("R7 clk low seen", v, 4'h6);
    rd(2'd2, v); chk("R5 src bit0", v, 4'h1);
    rd(2'd2, v); chk("R9 read cleared", v, 4'h0);
    @(negedge clk); dev_clk = 1;
    idle_cycles(10);
    rd(2'd2, v); chk("R5 rise no event", v, 4'h0);
  endtask

  task automatic t_glitch;
    @(negedge clk); dev_clk = 0;
    idle_cycles(2); dev_clk = 1;
    dev_dat = 0;
    idle_cycles(2); dev_dat = 1;
    idle_cycles(10);
    rd(2'd2, v); chk("R6 glitch no event", v, 4'h0);
    rd(2'd1, v); chk("R6 levels unchanged", v, 4'h7);
    @(negedge clk); dev_dat = 0;
    idle_cycles(8);
    rd(2'd1, v); chk("R7 data low seen", v, 4'h5);
    @(negedge clk); dev_dat = 1;
    idle_cycles(8);
  endtask

  task automatic t_enabled;
    wr(2'd0, 4'hD);
    @(negedge clk); dev_clk = 0;
    idle_cycles(10);
    rd(2'd2, v); chk("R11 no event when enabled", v, 4'h0);
    @(negedge clk); dev_clk = 1;
    idle_cycles(10);
    wr(2'd0, 4'hC);
  endtask

  task automatic t_idle;
    wr(2'd3, 4'h0);
    wr(2'd0, 4'hE);
    rd(2'd1, v); chk("R8 idle cleared", v, 4'h3);
    wr(2'd0, 4'hC);
    rd(2'd1, v); chk("R8 idle set", v, 4'h7);
    #1 chk("R10 masked irq", {3'b0, irq}, 4'h0);
    rd(2'd2, v); chk("R8 idle event", v, 4'h2);
    wr(2'd0, 4'hE); wr(2'd0, 4'hC);
    wr(2'd3, 4'h2); #1;
    chk("R10 unmasked irq", {3'b0, irq}, 4'h1);
    rd(2'd2, v);
  endtask

  task automatic t_same_cycle;
    rd(2'd2, v);
    @(negedge clk); dev_clk = 0;
    idle_cycles(4);
    @(negedge clk); bus_addr = 2'd2; bus_rd = 1; #1 v = bus_rdata;
    chk("R9 event not yet", v, 4'h0);
    @(negedge clk); bus_rd = 0;
    rd(2'd2, v); chk("R9 same-cycle event kept", v, 4'h1);
    @(negedge clk); dev_clk = 1;
    idle_cycles(10);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_lines;
    t_edge;
    t_glitch;
    t_enabled;
    t_idle;
    t_same_cycle;
    summary;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    summary;
  end
endmodule